// File: doc/BRIEF.md
# Branch Target Buffer

A small direct-mapped cache of branch targets that is read in the fetch stage with the current fetch address. When a valid entry holds the exact address being fetched, the block returns that entry's stored target as the next fetch address and raises a hit flag. Otherwise, fetch falls through to the next sequential word, `fetch_pc + 4`. Only branches that are expected to be taken occupy entries.

When a branch resolves later in the pipeline, an update port reports its address, its outcome, its target and the next address that fetch actually used for it. A taken branch is written into its indexed slot and displaces whatever was there before. A not-taken branch that still has an entry loses it. In the same cycle, the block compares the resolved successor with the address that fetch used. On a disagreement it raises a redirect carrying the corrected address, together with the number of penalty cycles to charge.

Fetch has no target for a branch that missed the buffer. For such a branch, a static direction rule at decode predicts taken when the branch points backward and not taken when it points forward.

Top module: `btb`

## Requirements
- R1: After reset every entry is invalid, so no fetch address hits until an update has written an entry.
- R2: The slot is selected by fetch_pc[IDX_W+1:2], and bits [AW-1:IDX_W+2] are compared in full against the stored branch address. When that slot is valid and the bits match, fetch_hit is 1 and next_pc equals the stored target.
- R3: When fetch misses, fetch_hit is 0 and next_pc equals fetch_pc + 4. This includes an address that selects an occupied slot but differs in its upper bits.
- R4: A resolved taken branch writes its address and target into its indexed slot and marks the slot valid, replacing any earlier occupant. Fetch sees the new entry from the cycle after the update.
- R5: A resolved not-taken branch whose address matches a valid entry invalidates that entry. A not-taken branch whose address does not match leaves the slot's occupant intact.
- R6: redirect is 1 in an update cycle when the resolved successor differs from upd_fetch_npc, the address fetch used. The resolved successor is upd_target if taken and upd_pc + 4 if not. In that case redirect_pc equals the resolved successor. Otherwise redirect is 0.
- R7: penalty is 2 in every update cycle that redirects and 0 in every other cycle. This covers a taken branch that missed (2), a hit branch that fell through (2), a hit branch that was taken (0) and a missed branch that fell through (0).
- R8: dec_static_taken is 1 only when dec_branch is 1, dec_fetch_hit is 0, and dec_target is below dec_pc as an unsigned number.
- R9: When fetch and an update address the same slot in one cycle, fetch sees the slot's contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all valid bits |
| fetch_pc | input | AW | Address being fetched this cycle |
| next_pc | output | AW | Next fetch address |
| fetch_hit | output | 1 | Fetch address found in the buffer |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_taken | input | 1 | Resolved outcome was taken |
| upd_pc | input | AW | Address of the resolved branch |
| upd_target | input | AW | Resolved taken target |
| upd_fetch_npc | input | AW | Next address that fetch used after this branch |
| redirect | output | 1 | Fetch went the wrong way; restart at redirect_pc |
| redirect_pc | output | AW | Corrected fetch address |
| penalty | output | PEN_W | Penalty cycles charged for this resolution |
| dec_branch | input | 1 | Instruction in decode is a branch |
| dec_fetch_hit | input | 1 | That branch hit the buffer at fetch |
| dec_pc | input | AW | Address of the decoded branch |
| dec_target | input | AW | Decoded branch target |
| dec_static_taken | output | 1 | Static fallback direction for a missed branch |

## Verification
The bench targets aliasing between two branches that share a slot. A design that matched only on the index would return one branch's target for the other. A design that invalidated on an index match alone would drop the occupant when its alias resolves not taken. The bench also covers all four combinations of hit/miss with taken/not-taken, to catch a penalty charged on a correct prediction or a redirect aimed at the wrong successor. An update and a fetch to the same slot in one cycle must return the old contents; a design that bypassed the write through would hit too early. The static rule is checked with a backward branch that hit, because a design that ignored the hit would override the buffer.

// File: rtl/btb.sv
module btb #(
  parameter int AW        = 32,
  parameter int IDX_W     = 4,
  parameter int PEN_W     = 2,
  parameter int MISS_COST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    fetch_pc,
  output logic [AW-1:0]    next_pc,
  output logic             fetch_hit,
  input  logic             upd_valid,
  input  logic             upd_taken,
  input  logic [AW-1:0]    upd_pc,
  input  logic [AW-1:0]    upd_target,
  input  logic [AW-1:0]    upd_fetch_npc,
  output logic             redirect,
  output logic [AW-1:0]    redirect_pc,
  output logic [PEN_W-1:0] penalty,
  input  logic             dec_branch,
  input  logic             dec_fetch_hit,
  input  logic [AW-1:0]    dec_pc,
  input  logic [AW-1:0]    dec_target,
  output logic             dec_static_taken
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = AW - IDX_W - 2;

  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [AW-1:0]    tgt_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  wire [IDX_W-1:0] f_idx = fetch_pc[IDX_W+1:2];
  wire [TAG_W-1:0] f_tag = fetch_pc[AW-1:IDX_W+2];
  wire [IDX_W-1:0] u_idx = upd_pc[IDX_W+1:2];
  wire [TAG_W-1:0] u_tag = upd_pc[AW-1:IDX_W+2];

  assign fetch_hit = vld_q[f_idx] && (tag_q[f_idx] == f_tag);
  assign next_pc   = fetch_hit ? tgt_q[f_idx] : fetch_pc + AW'(4);

  wire upd_match = vld_q[u_idx] && (tag_q[u_idx] == u_tag);
  wire do_write  = upd_valid && upd_taken;
  wire do_clear  = upd_valid && !upd_taken && upd_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (do_write && u_idx == IDX_W'(i))
          vld_q[i] <= 1'b1;
        else if (do_clear && u_idx == IDX_W'(i))
          vld_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_write) begin
      tag_q[u_idx] <= u_tag;
      tgt_q[u_idx] <= upd_target;
    end
  end

  wire [AW-1:0] resolved_npc = upd_taken ? upd_target : upd_pc + AW'(4);

  assign redirect    = upd_valid && (resolved_npc != upd_fetch_npc);
  assign redirect_pc = resolved_npc;
  assign penalty     = redirect ? PEN_W'(MISS_COST) : '0;

  assign dec_static_taken = dec_branch && !dec_fetch_hit && (dec_target < dec_pc);

  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !fetch_hit);

  a_r3_miss_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_hit |-> next_pc == fetch_pc + AW'(4));

  a_r4_taken_visible_next: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=>
      (fetch_pc != $past(upd_pc)) || (fetch_hit && next_pc == $past(upd_target)));

  a_r5_not_taken_removed: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> (fetch_pc != $past(upd_pc)) || !fetch_hit);

  a_r7_penalty_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (penalty != '0) |-> (redirect && upd_valid));

  a_r8_static_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    dec_static_taken |-> (dec_branch && !dec_fetch_hit));

endmodule

// File: tb/tb_btb.sv
module tb_btb;
  localparam int AW = 32;
  localparam int IDX_W = 4;
  localparam int STRIDE = (1 << IDX_W) * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0, next_pc;
  logic fetch_hit;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic [AW-1:0] upd_pc = '0, upd_target = '0, upd_fetch_npc = '0;
  logic redirect;
  logic [AW-1:0] redirect_pc;
  logic [1:0] penalty;
  logic dec_branch = 1'b0, dec_fetch_hit = 1'b0;
  logic [AW-1:0] dec_pc = '0, dec_target = '0;
  logic dec_static_taken;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  btb #(.AW(AW), .IDX_W(IDX_W), .PEN_W(2), .MISS_COST(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_pc(fetch_pc), .next_pc(next_pc), .fetch_hit(fetch_hit),
    .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_pc(upd_pc),
    .upd_target(upd_target), .upd_fetch_npc(upd_fetch_npc),
    .redirect(redirect), .redirect_pc(redirect_pc), .penalty(penalty),
    .dec_branch(dec_branch), .dec_fetch_hit(dec_fetch_hit),
    .dec_pc(dec_pc), .dec_target(dec_target),
    .dec_static_taken(dec_static_taken)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fetch_expect(input string req, input logic [AW-1:0] pc,
                              input logic hit, input logic [AW-1:0] npc);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    chk({req, " hit"}, AW'(fetch_hit), AW'(hit));
    chk({req, " next_pc"}, next_pc, npc);
  endtask

  task automatic resolve(input string req, input logic [AW-1:0] pc, input logic tk,
                         input logic [AW-1:0] tgt, input logic [AW-1:0] fnpc,
                         input logic exp_rd, input logic [AW-1:0] exp_rpc,
                         input logic [1:0] exp_pen);
    @(negedge clk);
    upd_valid = 1'b1; upd_taken = tk; upd_pc = pc; upd_target = tgt; upd_fetch_npc = fnpc;
    #1;
    chk({req, " redirect"}, AW'(redirect), AW'(exp_rd));
    if (exp_rd) chk({req, " redirect_pc"}, redirect_pc, exp_rpc);
    chk({req, " penalty"}, AW'(penalty), AW'(exp_pen));
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset;
    fetch_expect("R1", 32'h0000_0100, 1'b0, 32'h0000_0104);
    fetch_expect("R1", 32'h0000_0000, 1'b0, 32'h0000_0004);
    fetch_expect("R3", 32'h8000_003C, 1'b0, 32'h8000_0040);
  endtask

  task automatic t_alloc;
    resolve("R7 miss-taken R6", 32'h100, 1'b1, 32'h400, 32'h104, 1'b1, 32'h400, 2'd2);
    fetch_expect("R4 R2", 32'h100, 1'b1, 32'h400);
  endtask

  task automatic t_alias;
    fetch_expect("R3 alias", 32'h100 + STRIDE, 1'b0, 32'h100 + STRIDE + 4);
    resolve("R7 miss-nottaken", 32'h100 + STRIDE, 1'b0, 32'h900,
            32'h100 + STRIDE + 4, 1'b0, '0, 2'd0);
    fetch_expect("R5 alias kept", 32'h100, 1'b1, 32'h400);
  endtask

  task automatic t_hit_taken;
    resolve("R7 hit-taken", 32'h100, 1'b1, 32'h400, 32'h400, 1'b0, '0, 2'd0);
    fetch_expect("R2 still", 32'h100, 1'b1, 32'h400);
  endtask

  task automatic t_overwrite;
    resolve("R6 overwrite", 32'h100 + STRIDE, 1'b1, 32'h800, 32'h100 + STRIDE + 4,
            1'b1, 32'h800, 2'd2);
    fetch_expect("R4 new occupant", 32'h100 + STRIDE, 1'b1, 32'h800);
    fetch_expect("R4 old evicted", 32'h100, 1'b0, 32'h104);
  endtask

  task automatic t_invalidate;
    resolve("R7 hit-nottaken R6", 32'h100 + STRIDE, 1'b0, 32'h800, 32'h800,
            1'b1, 32'h100 + STRIDE + 4, 2'd2);
    fetch_expect("R5 removed", 32'h100 + STRIDE, 1'b0, 32'h100 + STRIDE + 4);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    fetch_pc = 32'h0C;
    upd_valid = 1'b1; upd_taken = 1'b1; upd_pc = 32'h0C;
    upd_target = 32'h200; upd_fetch_npc = 32'h10;
    #1;
    chk("R9 old contents hit", AW'(fetch_hit), '0);
    chk("R9 old contents next_pc", next_pc, 32'h10);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    chk("R9 after write", next_pc, 32'h200);
  endtask

  task automatic t_static;
    @(negedge clk);
    dec_branch = 1'b1; dec_fetch_hit = 1'b0; dec_pc = 32'h500; dec_target = 32'h480;
    #1 chk("R8 backward", AW'(dec_static_taken), 1);
    dec_target = 32'h580;
    #1 chk("R8 forward", AW'(dec_static_taken), 0);
    dec_target = 32'h480; dec_fetch_hit = 1'b1;
    #1 chk("R8 hit overrides", AW'(dec_static_taken), 0);
    dec_fetch_hit = 1'b0; dec_branch = 1'b0;
    #1 chk("R8 not branch", AW'(dec_static_taken), 0);
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alloc();
    t_alias();
    t_hit_taken();
    t_overwrite();
    t_invalidate();
    t_same_cycle();
    t_static();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule